// File: doc/BRIEF.md
# One-Line Multichannel Serial Audio Port

This block is a slave-mode time-division serial audio port. One serial input line carries six DAC channels and one serial output line carries six ADC channels, all inside a single word-clock frame. A second input line carries two more DAC channels as an ordinary stereo pair. The bit clock (`sclk`) and word clock (`lrck`) come from an external master. The block samples them with its own system clock `clk`, so that all logic runs in one clock domain.

A frame has two halves, selected by the `lrck` level, and each half lasts 64 bit-clock periods. Each half is split into three 20-bit channel slots followed by four padding periods. The slots are sent MSB first, and the first slot starts right at the `lrck` transition. Channels are interleaved between the halves: odd-numbered channels travel in the left half and even-numbered channels in the right half. Received slots are sign-extended to 24 bits and presented on parallel outputs. A one-cycle strobe marks a completed frame. The six parallel ADC words are captured once per frame and shifted out in the same slot layout.

Top module: `sap_oneline_port`

## Requirements
- R1: A half-frame is 64 `sclk` periods. `lrck` high selects the left half and low selects the right half. Each half holds three 20-bit slots, and the first slot begins with the first rising `sclk` edge after the `lrck` transition. `lrck` changes while `sclk` is low.
- R2: On `sdin_main`, left-half slots 0, 1 and 2 load `dac_main[0]`, `dac_main[2]` and `dac_main[4]` (DAC1, DAC3, DAC5). Right-half slots 0, 1 and 2 load `dac_main[1]`, `dac_main[3]` and `dac_main[5]` (DAC2, DAC4, DAC6).
- R3: On `sdin_pair`, only slot 0 is used. In the left half it loads `dac_pair[0]` (DAC7) and in the right half it loads `dac_pair[1]` (DAC8). All other `sdin_pair` periods have no effect.
- R4: Slots are received MSB first. The 20-bit slot value appears two's-complement sign-extended on the 24-bit outputs, so bits 23..20 copy slot bit 19.
- R5: `dac_valid` is high for exactly one `clk` cycle, one cycle after the last bit of the third right-half slot is sampled. It rises only if the left half of the same frame completed all three slots. In that cycle, all eight outputs already hold the frame's values.
- R6: `sdout` sends, MSB first, bits 23..4 of `adc_data[0]`, `adc_data[2]` and `adc_data[4]` in the three left-half slots, and of `adc_data[1]`, `adc_data[3]` and `adc_data[5]` in the three right-half slots.
- R7: Line values in the padding periods (bit positions 60 to 63 of a half) have no effect on any output. `sdout` is low during the padding periods.
- R8: Each `lrck` transition restarts the slot count. Until the first transition after reset, nothing is captured and `sdout` stays low. A half cut short by an early `lrck` transition produces no `dac_valid` for its frame, and the next complete frame is decoded correctly.
- R9: `adc_data` is sampled once per frame, at the falling `sclk` edge where `lrck` enters the left half. Later changes take effect only in the next frame.
- R10: After synchronous reset, `dac_main`, `dac_pair` and `dac_valid` are zero and `sdout` is low.
- R11: Input bits are sampled on rising `sclk` edges. `sdout` changes only after falling `sclk` edges and holds its value across each rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Bit clock from the external master |
| lrck | input | 1 | Word clock; high = left half |
| sdin_main | input | 1 | Serial line with six DAC channels |
| sdin_pair | input | 1 | Serial line with DAC7/DAC8 |
| adc_data | input | 6x24 | Parallel ADC samples, index 0 = ADC1 |
| dac_main | output | 6x24 | Received DAC1..DAC6, index 0 = DAC1 |
| dac_pair | output | 2x24 | Received DAC7 (index 0) and DAC8 (index 1) |
| dac_valid | output | 1 | One-cycle frame-complete strobe |
| sdout | output | 1 | Serial line with six ADC channels |

## Verification
The assertions assume the following about the inputs:
- Each `sclk` level lasts at least two `clk` cycles, so every edge is seen once.
- `lrck` and the data lines change only while `sclk` is low.
- No half-frame runs longer than 64 bit periods.

The bench holds each `sclk` level for four `clk` cycles and changes `lrck` and the data together with the falling edge. It runs halves of exactly 64 periods, except for one deliberately shortened half. It drives junk into the padding periods to show that they are ignored.

// File: rtl/sap_pkg.sv
// Shared constants and helpers for the one-line serial audio port.
// Assumes channel numbering interleaves halves: even index = left half.
package sap_pkg;

    // lrck level that marks the left half-frame
    localparam logic LEFT_LEVEL = 1'b1;

    // Channel index carried by a slot: left slots take even indices
    function automatic int chan_of(input int slot, input logic right_half);
        return 2 * slot + int'(right_half);
    endfunction

endpackage

// File: rtl/sap_pin_sync.sv
// Samples the serial pins with the system clock and produces one-cycle
// rising/falling events for sclk. Assumes each sclk level lasts at
// least two clk cycles. lrck and data are sampled with the same latency
// as sclk, so they line up with the edge events.
module sap_pin_sync #(
    parameter int NLINES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              lrck,
    input  logic [NLINES-1:0] sd,
    output logic              rise_ev,
    output logic              fall_ev,
    output logic              lrck_s,
    output logic [NLINES-1:0] sd_s
);
    logic sclk_q, sclk_qq;

    // Register the pins once and keep the previous sclk sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            sclk_qq <= 1'b0;
            lrck_s  <= 1'b0;
            sd_s    <= '0;
        end else begin
            sclk_q  <= sclk;
            sclk_qq <= sclk_q;
            lrck_s  <= lrck;
            sd_s    <= sd;
        end
    end

    assign rise_ev = sclk_q & ~sclk_qq;
    assign fall_ev = ~sclk_q & sclk_qq;

endmodule

// File: rtl/sap_frame_timer.sv
// Tracks the slot and bit position inside the current half-frame.
// An lrck change restarts the count. Position saturates in the padding
// area after the last slot. Provides the position of the bit about to
// be sampled (nxt_*), valid both at a rising event and at the falling
// event before it. Also flags frame completion.
module sap_frame_timer #(
    parameter int SLOT_W   = 20,
    parameter int SLOTS    = 3,
    parameter int HALF_LEN = 64,
    localparam int SW = $clog2(SLOTS + 1),
    localparam int BW = $clog2(SLOT_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise_ev,
    input  logic          lrck_s,
    output logic          half_left,
    output logic          new_half,
    output logic          aligned_nxt,
    output logic [SW-1:0] nxt_slot,
    output logic [BW-1:0] nxt_bit,
    output logic          frame_done
);
    import sap_pkg::*;

    localparam int HW = $clog2(HALF_LEN + 1);

    logic          lrck_last, aligned, left_done, slot_end;
    logic [SW-1:0] cur_slot;
    logic [BW-1:0] cur_bit;
    logic [HW-1:0] hcnt;

    assign half_left   = (lrck_s == LEFT_LEVEL);
    assign new_half    = lrck_s ^ lrck_last;
    assign aligned_nxt = aligned | new_half;

    // Position of the next bit: restart on a half change, else advance
    always_comb begin
        nxt_slot = cur_slot;
        nxt_bit  = cur_bit;
        if (new_half) begin
            nxt_slot = '0;
            nxt_bit  = '0;
        end else if (cur_slot == SW'(SLOTS)) begin
            nxt_slot = cur_slot;
        end else if (cur_bit == BW'(SLOT_W - 1)) begin
            nxt_slot = cur_slot + SW'(1);
            nxt_bit  = '0;
        end else begin
            nxt_bit  = cur_bit + BW'(1);
        end
    end

    assign slot_end   = rise_ev & aligned_nxt & (nxt_slot == SW'(SLOTS - 1))
                      & (nxt_bit == BW'(SLOT_W - 1));
    assign frame_done = slot_end & ~half_left & left_done;

    // Advance the position and alignment state on each sampled bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lrck_last <= 1'b0;
            aligned   <= 1'b0;
            cur_slot  <= SW'(SLOTS);
            cur_bit   <= '0;
        end else if (rise_ev) begin
            lrck_last <= lrck_s;
            cur_slot  <= nxt_slot;
            cur_bit   <= nxt_bit;
            if (new_half) aligned <= 1'b1;
        end
    end

    // Remember whether the left half of this frame finished its slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_done <= 1'b0;
        end else if (rise_ev && new_half && half_left) begin
            left_done <= 1'b0;
        end else if (slot_end && half_left) begin
            left_done <= 1'b1;
        end else if (frame_done) begin
            left_done <= 1'b0;
        end
    end

    // Count bit periods in the half (assertion support only)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
        end else if (rise_ev) begin
            if (new_half) hcnt <= HW'(1);
            else if (hcnt != HW'(HALF_LEN)) hcnt <= hcnt + HW'(1);
        end
    end

    assert_slot_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_slot <= SW'(SLOTS)) && (cur_bit <= BW'(SLOT_W - 1)));

    assert_half_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_ev && aligned && !new_half) |-> (hcnt < HW'(HALF_LEN)));

endmodule

// File: rtl/sap_deser.sv
// Shifts one serial line into 20-bit slot words and writes each
// completed word, sign-extended, into the channel register picked by
// slot and half. Only the first SLOTS_USED slots of a half are taken.
// Assumes the frame timer supplies the position of the sampled bit.
module sap_deser #(
    parameter int SLOT_W     = 20,
    parameter int OUT_W      = 24,
    parameter int SLOTS      = 3,
    parameter int SLOTS_USED = 3,
    parameter int NCH        = 6,
    localparam int SW = $clog2(SLOTS + 1),
    localparam int BW = $clog2(SLOT_W)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rise_ev,
    input  logic                      aligned_nxt,
    input  logic                      half_left,
    input  logic [SW-1:0]             nxt_slot,
    input  logic [BW-1:0]             nxt_bit,
    input  logic                      sd,
    output logic [NCH-1:0][OUT_W-1:0] data
);
    import sap_pkg::*;

    logic [SLOT_W-2:0] shreg;
    logic [SLOT_W-1:0] word;
    logic              take, last_bit;

    assign take     = rise_ev & aligned_nxt & (nxt_slot < SW'(SLOTS_USED));
    assign last_bit = (nxt_bit == BW'(SLOT_W - 1));
    assign word     = {shreg, sd};

    // Shift the sampled bit in, MSB first
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else if (take) shreg <= word[SLOT_W-2:0];
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        // Load this channel when its slot completes
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data[ch] <= '0;
            end else if (take && last_bit
                         && chan_of(int'(nxt_slot), ~half_left) == ch) begin
                data[ch] <= {{(OUT_W - SLOT_W){word[SLOT_W-1]}}, word};
            end
        end
    end

    assert_pad_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(data));

endmodule

// File: rtl/sap_ser.sv
// Drives the ADC samples onto the output line, one bit per falling
// sclk event. Each slot sends the top SLOT_W bits of a word, MSB first,
// and the padding periods are driven low. The sample set is captured
// at the falling edge that opens the left half.
module sap_ser #(
    parameter int SLOT_W = 20,
    parameter int OUT_W  = 24,
    parameter int SLOTS  = 3,
    parameter int NCH    = 6,
    localparam int SW = $clog2(SLOTS + 1),
    localparam int BW = $clog2(SLOT_W)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fall_ev,
    input  logic                      new_half,
    input  logic                      half_left,
    input  logic                      aligned_nxt,
    input  logic [SW-1:0]             nxt_slot,
    input  logic [BW-1:0]             nxt_bit,
    input  logic [NCH-1:0][OUT_W-1:0] adc_data,
    output logic                      sdout
);
    import sap_pkg::*;

    localparam int CW = $clog2(NCH);
    localparam int OW = $clog2(OUT_W);

    logic [NCH-1:0][OUT_W-1:0] snap, src;
    logic [CW-1:0]             ch_idx;
    logic [OW-1:0]             bit_idx;
    logic                      load, bit_val;

    assign load    = fall_ev & new_half & half_left;
    assign src     = load ? adc_data : snap;
    assign ch_idx  = CW'(chan_of(int'(nxt_slot), ~half_left));
    assign bit_idx = OW'(OUT_W - 1 - int'(nxt_bit));

    // Select the bit for the coming sample, low outside the slots
    always_comb begin
        bit_val = 1'b0;
        if (aligned_nxt && nxt_slot < SW'(SLOTS)) bit_val = src[ch_idx][bit_idx];
    end

    // Capture the frame's ADC samples at the start of the left half
    always_ff @(posedge clk) begin
        if (!rst_n) snap <= '0;
        else if (load) snap <= adc_data;
    end

    // Update the output line on falling sclk events only
    always_ff @(posedge clk) begin
        if (!rst_n) sdout <= 1'b0;
        else if (fall_ev) sdout <= bit_val;
    end

    assert_sdout_fall_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_ev |=> $stable(sdout));

    assert_pad_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_ev && nxt_slot == SW'(SLOTS)) |=> !sdout);

endmodule

// File: rtl/sap_oneline_port.sv
// Slave-mode one-line serial audio port: six DAC channels in on one
// line, two more on a stereo line, six ADC channels out on one line.
// Assumes sclk levels last at least two clk cycles and that lrck and
// data change while sclk is low.
module sap_oneline_port #(
    parameter int SLOT_W   = 20,
    parameter int SLOTS    = 3,
    parameter int HALF_LEN = 64,
    parameter int OUT_W    = 24,
    localparam int NCH = 2 * SLOTS,
    localparam int SW  = $clog2(SLOTS + 1),
    localparam int BW  = $clog2(SLOT_W)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sclk,
    input  logic                      lrck,
    input  logic                      sdin_main,
    input  logic                      sdin_pair,
    input  logic [NCH-1:0][OUT_W-1:0] adc_data,
    output logic [NCH-1:0][OUT_W-1:0] dac_main,
    output logic [1:0][OUT_W-1:0]     dac_pair,
    output logic                      dac_valid,
    output logic                      sdout
);
    logic          rise_ev, fall_ev, lrck_s, half_left, new_half;
    logic          aligned_nxt, frame_done;
    logic [1:0]    sd_s;
    logic [SW-1:0] nxt_slot;
    logic [BW-1:0] nxt_bit;

    sap_pin_sync #(.NLINES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk    (sclk),
        .lrck    (lrck),
        .sd      ({sdin_pair, sdin_main}),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev),
        .lrck_s  (lrck_s),
        .sd_s    (sd_s)
    );

    sap_frame_timer #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .HALF_LEN(HALF_LEN)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_ev     (rise_ev),
        .lrck_s      (lrck_s),
        .half_left   (half_left),
        .new_half    (new_half),
        .aligned_nxt (aligned_nxt),
        .nxt_slot    (nxt_slot),
        .nxt_bit     (nxt_bit),
        .frame_done  (frame_done)
    );

    sap_deser #(.SLOT_W(SLOT_W), .OUT_W(OUT_W), .SLOTS(SLOTS),
                .SLOTS_USED(SLOTS), .NCH(NCH)) u_deser_main (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_ev     (rise_ev),
        .aligned_nxt (aligned_nxt),
        .half_left   (half_left),
        .nxt_slot    (nxt_slot),
        .nxt_bit     (nxt_bit),
        .sd          (sd_s[0]),
        .data        (dac_main)
    );

    sap_deser #(.SLOT_W(SLOT_W), .OUT_W(OUT_W), .SLOTS(SLOTS),
                .SLOTS_USED(1), .NCH(2)) u_deser_pair (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_ev     (rise_ev),
        .aligned_nxt (aligned_nxt),
        .half_left   (half_left),
        .nxt_slot    (nxt_slot),
        .nxt_bit     (nxt_bit),
        .sd          (sd_s[1]),
        .data        (dac_pair)
    );

    sap_ser #(.SLOT_W(SLOT_W), .OUT_W(OUT_W), .SLOTS(SLOTS), .NCH(NCH)) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_ev     (fall_ev),
        .new_half    (new_half),
        .half_left   (half_left),
        .aligned_nxt (aligned_nxt),
        .nxt_slot    (nxt_slot),
        .nxt_bit     (nxt_bit),
        .adc_data    (adc_data),
        .sdout       (sdout)
    );

    // Register the frame-complete strobe alongside the data writes
    always_ff @(posedge clk) begin
        if (!rst_n) dac_valid <= 1'b0;
        else dac_valid <= frame_done;
    end

    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |=> !dac_valid);

    assert_valid_right_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |-> $past(!half_left));

endmodule

// File: tb/sap_oneline_port_bench.sv
module sap_oneline_port_bench;
    localparam int SLOT_W = 20;
    localparam int SLOTS  = 3;
    localparam int HALF   = 64;
    localparam int OUT_W  = 24;
    localparam int NCH    = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, sclk, lrck, sdin_main, sdin_pair;
    logic [NCH-1:0][OUT_W-1:0] adc_data;
    logic [NCH-1:0][OUT_W-1:0] dac_main;
    logic [1:0][OUT_W-1:0]     dac_pair;
    logic dac_valid, sdout;

    sap_oneline_port u_sap_oneline_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .lrck      (lrck),
        .sdin_main (sdin_main),
        .sdin_pair (sdin_pair),
        .adc_data  (adc_data),
        .dac_main  (dac_main),
        .dac_pair  (dac_pair),
        .dac_valid (dac_valid),
        .sdout     (sdout)
    );

    int n_checks = 0;
    int n_err    = 0;
    int valid_cnt = 0;
    int hold_err  = 0;
    logic [SLOT_W-1:0] dac_v [8];
    logic [OUT_W-1:0]  adc_exp [NCH];
    logic [NCH-1:0][OUT_W-1:0] adc_alt;
    logic sd_cap [2][HALF];
    logic [NCH-1:0][OUT_W-1:0] main_at_valid;
    logic [1:0][OUT_W-1:0]     pair_at_valid;

    // Record the outputs whenever the frame strobe is seen
    always @(negedge clk) begin
        if (rst_n && dac_valid) begin
            valid_cnt++;
            main_at_valid = dac_main;
            pair_at_valid = dac_pair;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [OUT_W-1:0] sext(input logic [SLOT_W-1:0] v);
        return {{(OUT_W - SLOT_W){v[SLOT_W-1]}}, v};
    endfunction

    function automatic logic [SLOT_W-1:0] dpat(input int k, input int ch);
        case (k)
            0: return SLOT_W'(1) << ((ch * 3 + 1) % SLOT_W);
            1: return '1;
            2: return (ch % 2 == 0) ? 20'h80000 : 20'h7FFFF;
            default: return SLOT_W'(k * 32'h2F3A1 + ch * 32'h1357B + 32'h9E37);
        endcase
    endfunction

    function automatic logic [OUT_W-1:0] apat(input int k, input int ch);
        return OUT_W'(k * 32'h5A3C91 + ch * 32'h1B2D4F + 32'h3C7);
    endfunction

    // One half-frame of nbits bit periods; lrck and data change with sclk low
    task automatic drive_half(input logic lr, input int nbits, input logic pad_v,
                              input int swap_at);
        for (int i = 0; i < nbits; i++) begin
            int s = i / SLOT_W;
            int b = i % SLOT_W;
            int r = lr ? 0 : 1;
            if (i == swap_at) adc_data = adc_alt;
            lrck = lr;
            sclk = 1'b0;
            if (s < SLOTS) sdin_main = dac_v[2 * s + r][SLOT_W-1-b];
            else sdin_main = pad_v;
            if (s == 0) sdin_pair = dac_v[6 + r][SLOT_W-1-b];
            else sdin_pair = pad_v;
            wait_clk(4);
            sd_cap[r][i] = sdout;
            sclk = 1'b1;
            wait_clk(4);
            if (sdout !== sd_cap[r][i]) hold_err++;
        end
    endtask

    task automatic load_frame(input int k);
        for (int ch = 0; ch < 8; ch++) dac_v[ch] = dpat(k, ch);
        for (int ch = 0; ch < NCH; ch++) begin
            adc_exp[ch]  = apat(k, ch);
            adc_data[ch] = adc_exp[ch];
            adc_alt[ch]  = ~adc_exp[ch];
        end
    endtask

    task automatic check_frame(input int v0);
        check(valid_cnt == v0 + 1, "R5", "valid pulses in frame", valid_cnt - v0, 1);
        for (int ch = 0; ch < NCH; ch++) begin
            check(main_at_valid[ch] == sext(dac_v[ch]), (ch % 2 == 0) ? "R2" : "R4",
                  $sformatf("dac_main[%0d]", ch), main_at_valid[ch], sext(dac_v[ch]));
        end
        for (int p = 0; p < 2; p++) begin
            check(pair_at_valid[p] == sext(dac_v[6 + p]), "R3",
                  $sformatf("dac_pair[%0d]", p), pair_at_valid[p], sext(dac_v[6 + p]));
        end
        for (int r = 0; r < 2; r++) begin
            for (int s = 0; s < SLOTS; s++) begin
                logic [SLOT_W-1:0] w;
                int ch = 2 * s + r;
                for (int b = 0; b < SLOT_W; b++) w[SLOT_W-1-b] = sd_cap[r][s * SLOT_W + b];
                check(w == adc_exp[ch][OUT_W-1:OUT_W-SLOT_W], "R6",
                      $sformatf("sdout slot for adc %0d", ch), w,
                      adc_exp[ch][OUT_W-1:OUT_W-SLOT_W]);
            end
            for (int b = SLOTS * SLOT_W; b < HALF; b++) begin
                check(sd_cap[r][b] == 1'b0, "R7", "sdout padding bit", sd_cap[r][b], 0);
            end
        end
    endtask

    task automatic run_frame(input int k, input logic pad_v, input int swap_at);
        int v0;
        load_frame(k);
        v0 = valid_cnt;
        drive_half(1'b1, HALF, pad_v, swap_at);
        drive_half(1'b0, HALF, pad_v, -1);
        check_frame(v0);
    endtask

    initial begin
        int v0;
        rst_n = 1'b0; sclk = 1'b0; lrck = 1'b0; sdin_main = 1'b0; sdin_pair = 1'b0;
        adc_data = '0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);

        // R10: reset state
        check(dac_main == '0, "R10", "dac_main after reset", 32'(dac_main[0]), 0);
        check(dac_pair == '0, "R10", "dac_pair after reset", 32'(dac_pair[0]), 0);
        check(dac_valid == 1'b0, "R10", "dac_valid after reset", 32'(dac_valid), 0);
        check(sdout == 1'b0, "R10", "sdout after reset", 32'(sdout), 0);

        // R8: no capture and no output before the first lrck transition
        load_frame(1);
        drive_half(1'b0, 40, 1'b1, -1);
        check(dac_main == '0 && dac_pair == '0, "R8", "capture before alignment",
              32'(dac_main[1]), 0);
        check(valid_cnt == 0, "R8", "valid before alignment", valid_cnt, 0);
        for (int i = 0; i < 40; i++)
            check(sd_cap[1][i] == 1'b0, "R8", "sdout before alignment", sd_cap[1][i], 0);

        // R1, R2, R3, R4, R6, R7: sweep of data patterns with junk padding
        for (int k = 0; k < 6; k++) run_frame(k, logic'(k % 2 == 0), -1);

        // R8: truncated left half gives no strobe, next frame recovers
        load_frame(6);
        v0 = valid_cnt;
        drive_half(1'b1, 30, 1'b1, -1);
        drive_half(1'b0, HALF, 1'b1, -1);
        check(valid_cnt == v0, "R8", "valid after truncated half", valid_cnt - v0, 0);
        run_frame(7, 1'b1, -1);

        // R9: change adc_data mid-frame, frame still carries the snapshot
        run_frame(8, 1'b0, 10);
        run_frame(9, 1'b1, -1);

        // R11: sdout held across every rising sclk edge
        check(hold_err == 0, "R11", "sdout changed after rising edge", hold_err, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule